// File: doc/BRIEF.md
# Two-Pixel Spectral Power Accumulator

This block builds a running sum of spectral power for a pair of pixels. It takes a stream of complex transform bins, each tagged with a pixel select and a bin index. For every bin it forms the squared magnitude (real squared plus imaginary squared) and adds it to that pixel's running-sum entry in on-chip RAM. The result is written back to the same entry. Repeating the pass over many measurements leaves a sum that a later stage can divide into an average.

Each pass has a fixed order. The local pixel (tag 0) is accumulated first. The block then waits until the partner pixel's results are flagged as available and accumulates the partner pixel (tag 1). A clear command zeroes the whole array at the start of a test. Between pixel pairs, the host reads the array out through the readout port, clears it, and starts again. The readout port is refused while a clear or a pass is running. Back-to-back updates to the same bin are handled by forwarding the value that is still being written. Sums saturate at full scale instead of wrapping.

Top module: `spectrum_power_accum`

## Requirements
- R1: After reset, `busy`, `done` and `rdValid` are all 0.
- R2: Pulsing `clrStart` while idle writes zero into every entry of both pixels. `busy` stays high for exactly 2*BINS cycles, and afterwards every entry reads 0.
- R3: Each accepted sample adds inRe*inRe + inIm*inIm to the entry addressed by (inPixel, inBin). `inRe` and `inIm` are signed two's complement.
- R4: Entries are not reset by a pass. A second pass without a clear adds on top of the first pass's totals.
- R5: After `passStart`, only samples with inPixel=0 are accepted, and samples with inPixel=1 are ignored. The local phase ends when the sample for bin BINS-1 of pixel 0 is accepted.
- R6: After the local phase, no sample is accepted until `partnerAvail` is seen high. After that, only samples with inPixel=1 are accepted, until bin BINS-1 of pixel 1.
- R7: Two or more consecutive accepted samples to the same bin each add their full power. No update is lost.
- R8: An entry whose sum would exceed 2^ACC_W-1 holds the value 2^ACC_W-1.
- R9: `done` rises one cycle after the last partner sample is accepted, which is the cycle after its write. At the same time `busy` falls. `done` returns to 0 on the next `passStart` or `clrStart`.
- R10: While idle, `rdEn` returns the entry (rdPixel, rdBin) on `rdData` with `rdValid`=1 in the next cycle. While `busy` is high, `rdEn` is ignored and `rdValid` stays 0.
- R11: `clrStart` and `passStart` are ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| clrStart | input | 1 | Start a zeroing sweep of the array |
| passStart | input | 1 | Start an accumulation pass |
| partnerAvail | input | 1 | Partner pixel results are available |
| inValid | input | 1 | Sample strobe |
| inPixel | input | 1 | Pixel tag: 0 local, 1 partner |
| inBin | input | log2(BINS) | Bin index of the sample |
| inRe | input | DATA_W | Signed real part |
| inIm | input | DATA_W | Signed imaginary part |
| rdEn | input | 1 | Readout request |
| rdPixel | input | 1 | Readout pixel select |
| rdBin | input | log2(BINS) | Readout bin index |
| rdData | output | ACC_W | Accumulated sum, valid with rdValid |
| rdValid | output | 1 | Readout data valid |
| busy | output | 1 | Clear or pass in progress |
| done | output | 1 | Pass finished, partner's last bin written |

## Verification
Two functions can fall in the same cycle: the write-back of one bin's new total, and the memory read for the next sample aimed at that same bin. The bench provokes this by sending a burst of three consecutive samples to one bin in the middle of the local phase. One sample in the burst is at full negative scale. A saturation pass repeats eight full-scale samples back to back on a single bin. Each case is judged by reading the entries back once the pass is idle. The readback is compared against a bench-side model that adds every accepted power and saturates; a lost or doubled update shows up as a mismatch.

// File: rtl/psa_pkg.sv
package psa_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_LOCAL,
    ST_WAIT,
    ST_PARTNER,
    ST_DRAIN
  } psaState_e;

  // strobes from control to datapath; at most one is high per cycle
  typedef struct packed {
    logic sampleTake;
    logic clearWe;
    logic hostRead;
  } psaStrobe_t;

endpackage

// File: rtl/psa_ctrl.sv
module psa_ctrl
  import psa_pkg::*;
#(
  parameter int BINS = 512
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       clrStart,
  input  logic                       passStart,
  input  logic                       partnerAvail,
  input  logic                       inValid,
  input  logic                       inPixel,
  input  logic [$clog2(BINS)-1:0]    inBin,
  input  logic                       rdEn,
  output psaStrobe_t                 strb,
  output logic [$clog2(BINS):0]      clrAddr,
  output logic                       busy,
  output logic                       done
);

  localparam int BW = $clog2(BINS);
  localparam int AW = BW + 1;
  localparam logic [AW-1:0] LAST_ADDR = AW'(2 * BINS - 1);
  localparam logic [BW-1:0] LAST_BIN  = BW'(BINS - 1);

  psaState_e state;
  logic      lastTake;

  always_comb begin
    strb.sampleTake = inValid &&
                      ((state == ST_LOCAL   && !inPixel) ||
                       (state == ST_PARTNER &&  inPixel));
    strb.clearWe    = (state == ST_CLEAR);
    strb.hostRead   = rdEn && (state == ST_IDLE);
    lastTake        = strb.sampleTake && (inBin == LAST_BIN);
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      clrAddr <= '0;
      done    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (clrStart) begin
            state   <= ST_CLEAR;
            clrAddr <= '0;
            done    <= 1'b0;
          end else if (passStart) begin
            state <= ST_LOCAL;
            done  <= 1'b0;
          end
        end
        ST_CLEAR: begin
          if (clrAddr == LAST_ADDR) state <= ST_IDLE;
          else                      clrAddr <= clrAddr + 1'b1;
        end
        ST_LOCAL:   if (lastTake)     state <= ST_WAIT;
        ST_WAIT:    if (partnerAvail) state <= ST_PARTNER;
        ST_PARTNER: if (lastTake)     state <= ST_DRAIN;
        ST_DRAIN: begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6: partner phase is entered only after partnerAvail was seen
  p_partner_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PARTNER && $past(state) == ST_WAIT) |-> $past(partnerAvail));

  // R9: done only rises on leaving the drain cycle
  p_done_after_drain_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> ($past(state) == ST_DRAIN && state == ST_IDLE));

  // R2: the sweep ends right after the top address
  p_clear_end_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CLEAR && clrAddr == LAST_ADDR) |=> (state == ST_IDLE));

  // R11: a clear request during a pass does not start a sweep
  p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && state != ST_CLEAR && clrStart) |=> (state != ST_CLEAR));

endmodule

// File: rtl/psa_datapath.sv
module psa_datapath
  import psa_pkg::*;
#(
  parameter int BINS   = 512,
  parameter int DATA_W = 24,
  parameter int ACC_W  = 64
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  psaStrobe_t                  strb,
  input  logic [$clog2(BINS):0]       clrAddr,
  input  logic                        inPixel,
  input  logic [$clog2(BINS)-1:0]     inBin,
  input  logic signed [DATA_W-1:0]    inRe,
  input  logic signed [DATA_W-1:0]    inIm,
  input  logic                        rdPixel,
  input  logic [$clog2(BINS)-1:0]     rdBin,
  output logic [ACC_W-1:0]            rdData,
  output logic                        rdValid
);

  localparam int BW    = $clog2(BINS);
  localparam int AW    = BW + 1;
  localparam int DEPTH = 2 * BINS;
  localparam int POW_W = 2 * DATA_W;

  logic [ACC_W-1:0] mem [DEPTH];
  logic [ACC_W-1:0] memRd;

  logic [AW-1:0]    takeAddr, readAddr;
  logic signed [POW_W-1:0] sqRe, sqIm;
  logic [POW_W-1:0] powNow;

  // stage 1: power and address of the sample being updated
  logic             s1Valid;
  logic [AW-1:0]    s1Addr;
  logic [POW_W-1:0] s1Pow;
  // stage 2: last written entry, kept for forwarding
  logic             s2Valid;
  logic [AW-1:0]    s2Addr;
  logic [ACC_W-1:0] s2Sum;

  logic [ACC_W-1:0] base, sumSat;
  logic [ACC_W:0]   wide;

  assign takeAddr = {inPixel, inBin};
  assign readAddr = strb.hostRead ? {rdPixel, rdBin} : takeAddr;
  assign sqRe     = inRe * inRe;
  assign sqIm     = inIm * inIm;
  assign powNow   = $unsigned(sqRe) + $unsigned(sqIm);

  always_comb begin
    base   = (s2Valid && s2Addr == s1Addr) ? s2Sum : memRd;
    wide   = {1'b0, base} + {{(ACC_W + 1 - POW_W){1'b0}}, s1Pow};
    sumSat = wide[ACC_W] ? '1 : wide[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    memRd <= mem[readAddr];
    if (strb.clearWe)  mem[clrAddr] <= '0;
    else if (s1Valid)  mem[s1Addr]  <= sumSat;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s1Addr  <= '0;
      s1Pow   <= '0;
      s2Valid <= 1'b0;
      s2Addr  <= '0;
      s2Sum   <= '0;
      rdValid <= 1'b0;
    end else begin
      s1Valid <= strb.sampleTake;
      s1Addr  <= takeAddr;
      s1Pow   <= powNow;
      s2Valid <= s1Valid;
      s2Addr  <= s1Addr;
      s2Sum   <= sumSat;
      rdValid <= strb.hostRead;
    end
  end

  assign rdData = rdValid ? memRd : '0;

  // R10: the single read port has one user per cycle
  p_one_user_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.sampleTake, strb.clearWe, strb.hostRead}));

  // R8: an update never makes an entry smaller (no wrap)
  p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rstN)
    s1Valid |-> (sumSat >= base));

  // R7: a same-bin follow-on update builds on the value just written
  p_forward_r7: assert property (@(posedge clk) disable iff (!rstN)
    (s1Valid && s2Valid && s1Addr == s2Addr) |-> (sumSat >= s2Sum));

endmodule

// File: rtl/spectrum_power_accum.sv
module spectrum_power_accum
  import psa_pkg::*;
#(
  parameter int BINS   = 512,
  parameter int DATA_W = 24,
  parameter int ACC_W  = 64
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        clrStart,
  input  logic                        passStart,
  input  logic                        partnerAvail,
  input  logic                        inValid,
  input  logic                        inPixel,
  input  logic [$clog2(BINS)-1:0]     inBin,
  input  logic signed [DATA_W-1:0]    inRe,
  input  logic signed [DATA_W-1:0]    inIm,
  input  logic                        rdEn,
  input  logic                        rdPixel,
  input  logic [$clog2(BINS)-1:0]     rdBin,
  output logic [ACC_W-1:0]            rdData,
  output logic                        rdValid,
  output logic                        busy,
  output logic                        done
);

  localparam int AW = $clog2(BINS) + 1;

  psaStrobe_t    strb;
  logic [AW-1:0] clrAddr;

  psa_ctrl #(.BINS(BINS)) uCtrl (
    .clk(clk), .rstN(rstN), .clrStart(clrStart), .passStart(passStart),
    .partnerAvail(partnerAvail), .inValid(inValid), .inPixel(inPixel),
    .inBin(inBin), .rdEn(rdEn), .strb(strb), .clrAddr(clrAddr),
    .busy(busy), .done(done)
  );

  psa_datapath #(.BINS(BINS), .DATA_W(DATA_W), .ACC_W(ACC_W)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .clrAddr(clrAddr),
    .inPixel(inPixel), .inBin(inBin), .inRe(inRe), .inIm(inIm),
    .rdPixel(rdPixel), .rdBin(rdBin), .rdData(rdData), .rdValid(rdValid)
  );

endmodule

// File: tb/tb_spectrum_power_accum.sv
module tb_spectrum_power_accum;

  localparam int BINS = 8;
  localparam int DW   = 24;
  localparam int AW   = 50;
  localparam int FULL = -8388608;

  logic clk, rstN, clrStart, passStart, partnerAvail, inValid, inPixel, rdEn, rdPixel;
  logic [2:0] inBin, rdBin;
  logic signed [DW-1:0] inRe, inIm;
  logic [AW-1:0] rdData;
  logic rdValid, busy, done;

  spectrum_power_accum #(.BINS(BINS), .DATA_W(DW), .ACC_W(AW)) dut (
    .clk(clk), .rstN(rstN), .clrStart(clrStart), .passStart(passStart),
    .partnerAvail(partnerAvail), .inValid(inValid), .inPixel(inPixel),
    .inBin(inBin), .inRe(inRe), .inIm(inIm), .rdEn(rdEn), .rdPixel(rdPixel),
    .rdBin(rdBin), .rdData(rdData), .rdValid(rdValid), .busy(busy), .done(done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;
  logic [AW-1:0] model [2][BINS];
  logic [AW-1:0] expQ [$];
  string         tagQ [$];

  task automatic check(input bit ok, input string tag,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rdValid === 1'b1) begin
      if (expQ.size() == 0) check(1'b0, "R10 unexpected rdValid", rdData, '0);
      else begin
        logic [AW-1:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(rdData === e, t, rdData, e);
      end
    end
  end

  function automatic logic [AW-1:0] powOf(input int re, input int im);
    longint r, i;
    r = re; i = im;
    return AW'(r * r + i * i);
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic sendSample(input bit pix, input int bin, input int re,
                            input int im, input bit take);
    logic [AW:0] w;
    inValid = 1'b1; inPixel = pix; inBin = 3'(bin);
    inRe = DW'(re); inIm = DW'(im);
    @(negedge clk);
    inValid = 1'b0;
    if (take) begin
      w = {1'b0, model[pix][bin]} + {1'b0, powOf(re, im)};
      model[pix][bin] = w[AW] ? '1 : w[AW-1:0];
    end
  endtask

  task automatic pulseClear();
    clrStart = 1'b1; @(negedge clk); clrStart = 1'b0;
  endtask

  task automatic pulseStart();
    passStart = 1'b1; @(negedge clk); passStart = 1'b0;
  endtask

  task automatic readEntry(input bit pix, input int bin, input string tag);
    rdEn = 1'b1; rdPixel = pix; rdBin = 3'(bin);
    expQ.push_back(model[pix][bin]);
    tagQ.push_back(tag);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic readAll(input string tag);
    for (int p = 0; p < 2; p++)
      for (int b = 0; b < BINS; b++) readEntry(p[0], b, tag);
    tick(); tick();
  endtask

  task automatic waitIdle();
    int guard = 0;
    while (busy === 1'b1 && guard < 1000) begin tick(); guard++; end
  endtask

  task automatic zeroModel();
    for (int p = 0; p < 2; p++)
      for (int b = 0; b < BINS; b++) model[p][b] = '0;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual hung, expected completion");
    summary();
  end

  initial begin
    int cnt;
    rstN = 1'b0; clrStart = 0; passStart = 0; partnerAvail = 0;
    inValid = 0; inPixel = 0; inBin = '0; inRe = '0; inIm = '0;
    rdEn = 0; rdPixel = 0; rdBin = '0;
    zeroModel();
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    check(busy == 1'b0,    "R1 busy after reset",    AW'(busy), '0);
    check(done == 1'b0,    "R1 done after reset",    AW'(done), '0);
    check(rdValid == 1'b0, "R1 rdValid after reset", AW'(rdValid), '0);

    // R2: clear sweep length and contents
    pulseClear();
    cnt = 0;
    while (busy === 1'b1 && cnt < 1000) begin cnt++; tick(); end
    check(cnt == 2 * BINS, "R2 clear busy cycles", AW'(cnt), AW'(2 * BINS));
    readAll("R2 cleared entry");

    // pass one
    pulseStart();
    check(done == 1'b0 && busy == 1'b1, "R9 start clears done", AW'(done), '0);
    rdEn = 1'b1; tick(); rdEn = 1'b0;
    check(rdValid == 1'b0, "R10 read blocked while busy", AW'(rdValid), '0);
    pulseClear(); // R11: must be ignored
    sendSample(1'b1, 2, 1000, 1000, 1'b0); // R5: partner sample ignored
    for (int b = 0; b < BINS - 1; b++)
      sendSample(1'b0, b, b * 1000 + 3, -(b * 500 + 1), 1'b1);
    // R7: burst to one bin
    sendSample(1'b0, 3, 70000, -90000, 1'b1);
    sendSample(1'b0, 3, FULL, 5, 1'b1);
    sendSample(1'b0, 3, 12345, -1, 1'b1);
    sendSample(1'b0, 7, -1, -1, 1'b1);
    // R6: waiting for partner, all samples ignored
    sendSample(1'b0, 5, 4444, 4444, 1'b0);
    sendSample(1'b1, 5, 4444, 4444, 1'b0);
    repeat (3) tick();
    check(busy == 1'b1 && done == 1'b0, "R6 holds until partnerAvail", AW'(done), '0);
    partnerAvail = 1'b1;
    tick();
    sendSample(1'b0, 1, 777, 777, 1'b0); // R6: local tag ignored in partner phase
    for (int b = 0; b < BINS - 1; b++)
      sendSample(1'b1, b, -(b * 3000 + 11), b * 7 + 2, 1'b1);
    pulseStart(); // R11: ignored
    sendSample(1'b1, 7, 31, -29, 1'b1);
    check(done == 1'b0, "R9 done not yet high", AW'(done), '0);
    tick();
    check(done == 1'b1, "R9 done after last write", AW'(done), AW'(1));
    check(busy == 1'b0, "R9 busy falls with done", AW'(busy), '0);
    partnerAvail = 1'b0;
    readAll("R3 R5 R6 R7 R11 pass one entry");

    // R4: second pass on top of the first
    pulseStart();
    for (int b = 0; b < BINS; b++)
      sendSample(1'b0, b, 4000 - b * 999, b * 123, 1'b1);
    partnerAvail = 1'b1;
    tick();
    for (int b = 0; b < BINS; b++)
      sendSample(1'b1, BINS - 1 - b == 7 ? 0 : BINS - 1 - b, b * 50001, -b, 1'b1);
    sendSample(1'b1, 7, 8, 9, 1'b1);
    tick();
    partnerAvail = 1'b0;
    waitIdle();
    readAll("R4 second pass entry");

    // R8: saturation
    pulseClear();
    waitIdle();
    zeroModel();
    pulseStart();
    for (int k = 0; k < 8; k++) sendSample(1'b0, 0, FULL, FULL, 1'b1);
    sendSample(1'b0, 7, 1, 0, 1'b1);
    partnerAvail = 1'b1;
    tick();
    sendSample(1'b1, 7, 0, 0, 1'b1);
    tick();
    partnerAvail = 1'b0;
    waitIdle();
    check(model[0][0] == '1, "R8 model at full scale", model[0][0], '1);
    readEntry(1'b0, 0, "R8 saturated entry");
    readEntry(1'b0, 7, "R8 neighbour entry");
    readEntry(1'b1, 0, "R8 untouched entry");
    tick(); tick();
    summary();
  end

endmodule